// File: doc/BRIEF.md
# Wakeup-and-Select Instruction Station

This block is the holding area that sits in front of a single execution unit in an out-of-order core. The front end writes one instruction per cycle into a free slot. Each instruction carries an opcode, a destination tag and two source operands. A source whose value is already known arrives as data. A source still being computed arrives as the tag of the instruction that will produce it. The slot then snoops a result bus. When a result carries the awaited tag, the slot grabs the value.

Every cycle the block offers at most one instruction to the execution unit. The offered instruction is one whose two sources are both present. When several qualify, the one that entered earliest goes first. A later instruction whose sources are present can therefore overtake an earlier one that is still waiting. The execution unit takes whatever is offered, and the slot becomes free at the next clock edge.

Each slot is marked speculative or not when it is written. A flush discards every speculative slot at once.

Top module: `rs_wakeup_station`

## Requirements
- R1: After reset no instruction is offered (`iss_valid` = 0) and `full` = 0.
- R2: A source written with its ready flag at 1 keeps the written data. A source written with its ready flag at 0 waits on the written tag, and the data supplied with it is discarded.
- R3: A waiting source whose tag equals `bc_tag` while `bc_valid` = 1 holds `bc_data` from the next cycle on. A broadcast with a different tag leaves it waiting.
- R4: A source written while waiting, in the same cycle as a broadcast of its tag, is captured as ready with `bc_data`. It is not left waiting.
- R5: An instruction is offered only when both of its sources are ready. The offered opcode, destination tag and source values appear on the `iss_*` ports in the same cycle as `iss_valid`.
- R6: An offered instruction is always taken. Its slot is free from the next clock edge on, and the instruction is never offered twice.
- R7: Among the instructions ready in a cycle, the one written earliest is offered, whatever slot it occupies. A ready instruction is offered ahead of older ones that are still waiting.
- R8: `full` = 1 exactly when all DEPTH slots are occupied. A write attempted while `full` = 1 is dropped and is never offered.
- R9: In a cycle with `flush` = 1, every slot marked speculative is freed. A speculative write in that cycle is dropped. Non-speculative slots and non-speculative writes are kept.
- R10: In a cycle with `flush` = 1, no speculative instruction is offered, even one whose sources are ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Write an instruction this cycle |
| disp_spec | input | 1 | Instruction is speculative |
| disp_op | input | OP_W | Opcode |
| disp_dst | input | TAG_W | Destination tag |
| disp_a_rdy | input | 1 | Source A carries data (1) or a tag (0) |
| disp_a_tag | input | TAG_W | Producer tag of source A |
| disp_a_data | input | DATA_W | Value of source A |
| disp_b_rdy | input | 1 | Source B carries data (1) or a tag (0) |
| disp_b_tag | input | TAG_W | Producer tag of source B |
| disp_b_data | input | DATA_W | Value of source B |
| full | output | 1 | No free slot; writes are dropped |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of broadcast result |
| bc_data | input | DATA_W | Broadcast value |
| flush | input | 1 | Discard speculative instructions |
| iss_valid | output | 1 | Instruction offered to the execution unit |
| iss_op | output | OP_W | Offered opcode |
| iss_dst | output | TAG_W | Offered destination tag |
| iss_a | output | DATA_W | Offered source A value |
| iss_b | output | DATA_W | Offered source B value |

## Verification
The hardest situation to reach is age order disagreeing with slot order. This needs an old instruction to leave and a newer one to take the freed low slot while older instructions are still waiting.

The stimulus creates it in four steps:
1. Wake only the first of three waiting instructions on a private tag, so that it issues.
2. Write a fourth instruction, which lands in the vacated slot 0.
3. Release the remaining three together with one shared broadcast.
4. Check that the issue order follows the write order rather than the slot index.

The flush cycle that also carries a broadcast and a ready speculative candidate is driven on purpose. It shows selection filtering and wakeup acting in the same edge.

// File: rtl/rs_pkg.sv
package rs_pkg;

   typedef enum logic {
      PICK_OLDEST      = 1'b0,
      PICK_LOWEST_SLOT = 1'b1
   } pick_policy_e;

   localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
   parameter int unsigned TAG_W  = 5,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ld_rdy,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              rdy,
   output logic [TAG_W-1:0]  tag,
   output logic [DATA_W-1:0] data
);

   logic hit_new;
   logic hit_held;

   assign hit_new  = bc_valid && !ld_rdy && (bc_tag == ld_tag);
   assign hit_held = bc_valid && !rdy && (bc_tag == tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy  <= 1'b0;
         tag  <= '0;
         data <= '0;
      end else if (load) begin
         rdy  <= ld_rdy || hit_new;
         tag  <= ld_tag;
         data <= ld_rdy ? ld_data : (hit_new ? bc_data : '0);
      end else if (hit_held) begin
         rdy  <= 1'b1;
         data <= bc_data;
      end
   end

endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
   parameter int unsigned OP_W   = 4,
   parameter int unsigned TAG_W  = 5,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned AGE_W  = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               load,
   input  logic                               kill,
   input  logic                               bump,
   input  logic [AGE_W-1:0]                   dec,
   input  logic                               ld_spec,
   input  logic [OP_W-1:0]                    ld_op,
   input  logic [TAG_W-1:0]                   ld_dst,
   input  logic [rs_pkg::NUM_SRC-1:0]         ld_rdy,
   input  logic [rs_pkg::NUM_SRC-1:0][TAG_W-1:0]  ld_tag,
   input  logic [rs_pkg::NUM_SRC-1:0][DATA_W-1:0] ld_data,
   input  logic                               bc_valid,
   input  logic [TAG_W-1:0]                   bc_tag,
   input  logic [DATA_W-1:0]                  bc_data,
   output logic                               valid,
   output logic                               spec,
   output logic                               ready,
   output logic [OP_W-1:0]                    op,
   output logic [TAG_W-1:0]                   dst,
   output logic [AGE_W-1:0]                   age,
   output logic [rs_pkg::NUM_SRC-1:0]         rdy,
   output logic [rs_pkg::NUM_SRC-1:0][TAG_W-1:0]  tag,
   output logic [rs_pkg::NUM_SRC-1:0][DATA_W-1:0] data
);

   for (genvar s = 0; s < rs_pkg::NUM_SRC; s++) begin : g_src
      rs_operand #(
         .TAG_W  (TAG_W),
         .DATA_W (DATA_W)
      ) u_opnd (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load),
         .ld_rdy   (ld_rdy[s]),
         .ld_tag   (ld_tag[s]),
         .ld_data  (ld_data[s]),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_data  (bc_data),
         .rdy      (rdy[s]),
         .tag      (tag[s]),
         .data     (data[s])
      );
   end

   assign ready = valid && (&rdy);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         spec  <= 1'b0;
         op    <= '0;
         dst   <= '0;
         age   <= '0;
      end else if (load) begin
         valid <= 1'b1;
         spec  <= ld_spec;
         op    <= ld_op;
         dst   <= ld_dst;
         age   <= '0;
      end else if (kill) begin
         valid <= 1'b0;
         spec  <= 1'b0;
      end else if (valid) begin
         age   <= age + AGE_W'(bump) - dec;
      end
   end

endmodule

// File: rtl/rs_select.sv
module rs_select #(
   parameter int unsigned          DEPTH = 4,
   parameter int unsigned          AGE_W = 2,
   parameter int unsigned          IDX_W = 2,
   parameter rs_pkg::pick_policy_e PICK  = rs_pkg::PICK_OLDEST
) (
   input  logic [DEPTH-1:0]            elig,
   input  logic [DEPTH-1:0][AGE_W-1:0] age,
   output logic [DEPTH-1:0]            grant,
   output logic                        any,
   output logic [IDX_W-1:0]            idx
);

   assign any   = |elig;
   assign grant = any ? (DEPTH'(1) << idx) : '0;

   if (PICK == rs_pkg::PICK_OLDEST) begin : g_oldest
      always_comb begin
         logic             found;
         logic [AGE_W-1:0] best;
         found = 1'b0;
         best  = '0;
         idx   = '0;
         for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && (!found || age[i] > best)) begin
               found = 1'b1;
               best  = age[i];
               idx   = IDX_W'(i);
            end
         end
      end
   end else begin : g_lowest
      always_comb begin
         idx = '0;
         for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/rs_wakeup_station.sv
module rs_wakeup_station
   import rs_pkg::*;
#(
   parameter int unsigned  DEPTH  = 4,
   parameter int unsigned  OP_W   = 4,
   parameter int unsigned  TAG_W  = 5,
   parameter int unsigned  DATA_W = 16,
   parameter pick_policy_e PICK   = PICK_OLDEST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic              disp_spec,
   input  logic [OP_W-1:0]   disp_op,
   input  logic [TAG_W-1:0]  disp_dst,
   input  logic              disp_a_rdy,
   input  logic [TAG_W-1:0]  disp_a_tag,
   input  logic [DATA_W-1:0] disp_a_data,
   input  logic              disp_b_rdy,
   input  logic [TAG_W-1:0]  disp_b_tag,
   input  logic [DATA_W-1:0] disp_b_data,
   output logic              full,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   input  logic              flush,
   output logic              iss_valid,
   output logic [OP_W-1:0]   iss_op,
   output logic [TAG_W-1:0]  iss_dst,
   output logic [DATA_W-1:0] iss_a,
   output logic [DATA_W-1:0] iss_b
);

   localparam int unsigned AGE_W = $clog2(DEPTH);
   localparam int unsigned IDX_W = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_chk_depth
      $error("rs_wakeup_station: DEPTH must be at least 2");
   end
   if (TAG_W < 1 || DATA_W < 1 || OP_W < 1) begin : g_chk_width
      $error("rs_wakeup_station: widths must be nonzero");
   end

   logic [DEPTH-1:0]                             ent_valid;
   logic [DEPTH-1:0]                             ent_spec;
   logic [DEPTH-1:0]                             ent_ready;
   logic [DEPTH-1:0]                             ent_load;
   logic [DEPTH-1:0]                             ent_kill;
   logic [DEPTH-1:0]                             ent_elig;
   logic [DEPTH-1:0]                             sel_grant;
   logic [DEPTH-1:0]                             free_vec;
   logic [DEPTH-1:0]                             free_oh;
   logic [DEPTH-1:0][NUM_SRC-1:0]                ent_rdy;
   logic [DEPTH-1:0][NUM_SRC-1:0][TAG_W-1:0]     ent_tag;
   logic [DEPTH-1:0][NUM_SRC-1:0][DATA_W-1:0]    ent_data;
   logic [DEPTH-1:0][OP_W-1:0]                   ent_op;
   logic [DEPTH-1:0][TAG_W-1:0]                  ent_dst;
   logic [DEPTH-1:0][AGE_W-1:0]                  ent_age;
   logic [IDX_W-1:0]                             sel_idx;
   logic                                         sel_any;
   logic                                         disp_take;
   logic [NUM_SRC-1:0]                           ld_rdy;
   logic [NUM_SRC-1:0][TAG_W-1:0]                ld_tag;
   logic [NUM_SRC-1:0][DATA_W-1:0]               ld_data;

   // slot allocation: lowest free index
   assign full      = &ent_valid;
   assign free_vec  = ~ent_valid;
   assign free_oh   = free_vec & (~free_vec + DEPTH'(1));
   assign disp_take = disp_valid && !full && !(flush && disp_spec);
   assign ent_load  = disp_take ? free_oh : '0;

   assign ld_rdy  = {disp_b_rdy, disp_a_rdy};
   assign ld_tag  = {disp_b_tag, disp_a_tag};
   assign ld_data = {disp_b_data, disp_a_data};

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [AGE_W-1:0] dec;

      assign ent_elig[i] = ent_ready[i] && !(flush && ent_spec[i]);
      assign ent_kill[i] = sel_grant[i] || (flush && ent_valid[i] && ent_spec[i]);

      // count departing entries younger than this one to keep ages compact
      always_comb begin
         dec = '0;
         for (int j = 0; j < DEPTH; j++) begin
            if (ent_kill[j] && ent_valid[j] && (ent_age[j] < ent_age[i]))
               dec = dec + AGE_W'(1);
         end
      end

      rs_entry #(
         .OP_W   (OP_W),
         .TAG_W  (TAG_W),
         .DATA_W (DATA_W),
         .AGE_W  (AGE_W)
      ) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (ent_load[i]),
         .kill     (ent_kill[i]),
         .bump     (disp_take),
         .dec      (dec),
         .ld_spec  (disp_spec),
         .ld_op    (disp_op),
         .ld_dst   (disp_dst),
         .ld_rdy   (ld_rdy),
         .ld_tag   (ld_tag),
         .ld_data  (ld_data),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_data  (bc_data),
         .valid    (ent_valid[i]),
         .spec     (ent_spec[i]),
         .ready    (ent_ready[i]),
         .op       (ent_op[i]),
         .dst      (ent_dst[i]),
         .age      (ent_age[i]),
         .rdy      (ent_rdy[i]),
         .tag      (ent_tag[i]),
         .data     (ent_data[i])
      );
   end

   rs_select #(
      .DEPTH (DEPTH),
      .AGE_W (AGE_W),
      .IDX_W (IDX_W),
      .PICK  (PICK)
   ) u_sel (
      .elig  (ent_elig),
      .age   (ent_age),
      .grant (sel_grant),
      .any   (sel_any),
      .idx   (sel_idx)
   );

   assign iss_valid = sel_any;
   assign iss_op    = ent_op[sel_idx];
   assign iss_dst   = ent_dst[sel_idx];
   assign iss_a     = ent_data[sel_idx][0];
   assign iss_b     = ent_data[sel_idx][1];

endmodule

// File: rtl/rs_wakeup_checker.sv
module rs_wakeup_checker #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned TAG_W = 5,
   parameter int unsigned AGE_W = 2
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               full,
   input logic                               flush,
   input logic                               bc_valid,
   input logic [TAG_W-1:0]                   bc_tag,
   input logic                               iss_valid,
   input logic [DEPTH-1:0]                   valid,
   input logic [DEPTH-1:0]                   spec,
   input logic [DEPTH-1:0]                   grant,
   input logic [DEPTH-1:0][1:0]              rdy,
   input logic [DEPTH-1:0][1:0][TAG_W-1:0]   tag,
   input logic [DEPTH-1:0][AGE_W-1:0]        age
);

   logic [TAG_W-1:0] prev_tag;
   logic [DEPTH-1:0] both_rdy;
   logic             stale_wait;
   logic             age_clash;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_tag <= '0;
      else        prev_tag <= bc_tag;
   end

   always_comb begin
      stale_wait = 1'b0;
      age_clash  = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         both_rdy[i] = rdy[i][0] && rdy[i][1];
         for (int s = 0; s < 2; s++) begin
            if (valid[i] && !rdy[i][s] && (tag[i][s] == prev_tag)) stale_wait = 1'b1;
         end
         for (int j = i + 1; j < DEPTH; j++) begin
            if (valid[i] && valid[j] && (age[i] == age[j])) age_clash = 1'b1;
         end
      end
   end

   AST_BCAST_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid |=> !stale_wait); // R3
   AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> ((grant & valid & both_rdy) != '0)); // R5
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R6
   AST_ISSUED_FREED: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |=> ((valid & $past(grant)) == '0)); // R6
   AST_AGE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      !age_clash); // R7
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !iss_valid && !flush) |=> (valid == $past(valid))); // R8
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ((valid & spec) == '0)); // R9
   AST_FLUSH_NO_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && iss_valid) |-> ((grant & spec) == '0)); // R10

endmodule

bind rs_wakeup_station rs_wakeup_checker #(
   .DEPTH (DEPTH),
   .TAG_W (TAG_W),
   .AGE_W ($clog2(DEPTH))
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .full      (full),
   .flush     (flush),
   .bc_valid  (bc_valid),
   .bc_tag    (bc_tag),
   .iss_valid (iss_valid),
   .valid     (ent_valid),
   .spec      (ent_spec),
   .grant     (sel_grant),
   .rdy       (ent_rdy),
   .tag       (ent_tag),
   .age       (ent_age)
);

// File: tb/rs_wakeup_station_bench.sv
`timescale 1ns/1ps
module rs_wakeup_station_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_valid, disp_spec, disp_a_rdy, disp_b_rdy;
   logic [3:0]  disp_op;
   logic [4:0]  disp_dst, disp_a_tag, disp_b_tag;
   logic [15:0] disp_a_data, disp_b_data;
   logic        full;
   logic        bc_valid;
   logic [4:0]  bc_tag;
   logic [15:0] bc_data;
   logic        flush;
   logic        iss_valid;
   logic [3:0]  iss_op;
   logic [4:0]  iss_dst;
   logic [15:0] iss_a, iss_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rs_wakeup_station u_rs_wakeup_station (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_spec(disp_spec), .disp_op(disp_op), .disp_dst(disp_dst),
      .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_data(disp_a_data),
      .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_data(disp_b_data),
      .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data), .flush(flush),
      .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr();
      disp_valid = 0; disp_spec = 0; disp_op = 0; disp_dst = 0;
      disp_a_rdy = 0; disp_a_tag = 0; disp_a_data = 0;
      disp_b_rdy = 0; disp_b_tag = 0; disp_b_data = 0;
      bc_valid = 0; bc_tag = 0; bc_data = 0; flush = 0;
   endtask

   task automatic step();
      @(posedge clk); #1; clr(); #1;
   endtask

   task automatic put(input logic [3:0] op, input logic sp,
                      input logic ar, input logic [4:0] at, input logic [15:0] ad,
                      input logic br, input logic [4:0] bt, input logic [15:0] bd);
      disp_valid = 1; disp_spec = sp; disp_op = op; disp_dst = {1'b1, op};
      disp_a_rdy = ar; disp_a_tag = at; disp_a_data = ad;
      disp_b_rdy = br; disp_b_tag = bt; disp_b_data = bd;
   endtask

   task automatic bcast(input logic [4:0] t, input logic [15:0] d);
      bc_valid = 1; bc_tag = t; bc_data = d;
   endtask

   task automatic expect_op(input string req, input logic [3:0] op);
      check({req, " iss_valid"}, 32'(iss_valid), 32'd1);
      check({req, " iss_op"}, 32'(iss_op), 32'(op));
   endtask

   task automatic expect_none(input string req);
      check({req, " idle"}, 32'(iss_valid), 32'd0);
   endtask

   task automatic t_reset();
      expect_none("R1");
      check("R1 full", 32'(full), 32'd0);
   endtask

   task automatic t_ready_issue();
      put(4'd3, 0, 1, 5'd0, 16'h1111, 1, 5'd0, 16'h2222); step();
      expect_op("R2/R5", 4'd3);
      check("R2 a", 32'(iss_a), 32'h1111);
      check("R2 b", 32'(iss_b), 32'h2222);
      check("R5 dst", 32'(iss_dst), 32'h13);
      step();
      expect_none("R6");
   endtask

   task automatic t_tag_wakeup();
      put(4'd5, 0, 0, 5'd4, 16'h5555, 0, 5'd9, 16'h5555); step();
      expect_none("R5 waiting");
      bcast(5'd12, 16'hDEAD); step();
      expect_none("R3 other tag");
      bcast(5'd4, 16'hAAAA); step();
      expect_none("R5 one source");
      bcast(5'd9, 16'hBBBB); step();
      expect_op("R3", 4'd5);
      check("R2/R3 a", 32'(iss_a), 32'hAAAA);
      check("R3 b", 32'(iss_b), 32'hBBBB);
      step();
      expect_none("R6");
   endtask

   task automatic t_same_cycle();
      put(4'd6, 0, 0, 5'd11, 16'h0000, 1, 5'd0, 16'h0042);
      bcast(5'd11, 16'h7777); step();
      expect_op("R4", 4'd6);
      check("R4 a", 32'(iss_a), 32'h7777);
      check("R4 b", 32'(iss_b), 32'h0042);
      step();
      expect_none("R4");
   endtask

   task automatic t_bypass();
      put(4'd1, 0, 0, 5'd3, 16'h0, 1, 5'd0, 16'h1); step();
      put(4'd2, 0, 1, 5'd0, 16'h2, 1, 5'd0, 16'h2); step();
      expect_op("R7 younger first", 4'd2);
      step();
      expect_none("R7");
      bcast(5'd3, 16'h3333); step();
      expect_op("R7 older later", 4'd1);
      step();
      expect_none("R7");
   endtask

   task automatic t_oldest();
      put(4'd1, 0, 0, 5'd2, 16'h0, 1, 5'd0, 16'h0); step();
      put(4'd2, 0, 0, 5'd9, 16'h0, 1, 5'd0, 16'h0); step();
      put(4'd3, 0, 0, 5'd9, 16'h0, 1, 5'd0, 16'h0); step();
      bcast(5'd2, 16'h0002); step();
      expect_op("R7 first", 4'd1);
      step();
      put(4'd4, 0, 0, 5'd9, 16'h0, 1, 5'd0, 16'h0); step();
      expect_none("R7");
      bcast(5'd9, 16'h0009); step();
      expect_op("R7 age order 1", 4'd2); step();
      expect_op("R7 age order 2", 4'd3); step();
      expect_op("R7 age order 3", 4'd4); step();
      expect_none("R7");
   endtask

   task automatic t_full();
      for (int k = 0; k < 4; k++) begin
         put(4'(8 + k), 0, 0, 5'd15, 16'h0, 1, 5'd0, 16'h0); step();
      end
      check("R8 full", 32'(full), 32'd1);
      put(4'd12, 0, 0, 5'd15, 16'h0, 1, 5'd0, 16'h0); step();
      check("R8 still full", 32'(full), 32'd1);
      bcast(5'd15, 16'h00FF); step();
      expect_op("R8 drain 0", 4'd8); step();
      check("R8 not full", 32'(full), 32'd0);
      expect_op("R8 drain 1", 4'd9); step();
      expect_op("R8 drain 2", 4'd10); step();
      expect_op("R8 drain 3", 4'd11); step();
      expect_none("R8 dropped write");
   endtask

   task automatic t_flush();
      put(4'd1, 1, 0, 5'd6, 16'h0, 1, 5'd0, 16'h0); step();
      put(4'd2, 0, 0, 5'd6, 16'h0, 1, 5'd0, 16'h0); step();
      put(4'd3, 1, 1, 5'd0, 16'h3, 1, 5'd0, 16'h3); flush = 1; step();
      expect_none("R9 spec write dropped");
      bcast(5'd6, 16'h0006); step();
      expect_op("R9 nonspec kept", 4'd2); step();
      expect_none("R9 spec gone");
      put(4'd5, 0, 0, 5'd1, 16'h0, 1, 5'd0, 16'h0); step();
      put(4'd4, 1, 1, 5'd0, 16'h4, 1, 5'd0, 16'h4); step();
      expect_op("R10 spec candidate", 4'd4);
      flush = 1; bcast(5'd1, 16'h0101); #1;
      expect_none("R10");
      step();
      expect_op("R9 survivor", 4'd5);
      check("R9 survivor a", 32'(iss_a), 32'h0101);
      step();
      expect_none("R9");
   endtask

   initial begin
      clr();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1; #1;
      t_reset();
      t_ready_issue();
      t_tag_wakeup();
      t_same_cycle();
      t_bypass();
      t_oldest();
      t_full();
      t_flush();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule